// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides whether a received CAN identifier is wanted and where it should go. It holds a bank of programmable filters and a small pool of shared masks. Each filter picks one mask through a 2-bit selector, and each filter names a destination FIFO through a 5-bit selector. A decoded identifier arrives with a strobe. One clock later the block reports whether any enabled filter matched, the number of the winning filter and its destination FIFO.

Both standard (11-bit) and extended (11+18-bit) identifiers are handled. A single write port programs the filter words, the mask words and the packed control bytes. Bit-level reception and message storage sit outside this block.

Top module: `can_filter_bank`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `id_valid` high, and low otherwise. The other result outputs are updated only when `res_valid` rises.
- R2: A mask bit of 1 makes the matching identifier bit compare against the filter bit, and a mask bit of 0 makes that bit a don't-care. Filter and mask words carry the standard ID in bits 31:21 and the extended ID in bits 17:0. The 18 extended bits are compared only for frames with `id_ext`=1.
- R3: Mask bit 19 is the type check. When it is 1, `id_ext` must equal filter bit 19, the filter's extended flag. When it is 0, both frame types can match.
- R4: A filter's 2-bit mask select uses the values 0 to 3 to pick masks 0 to 3.
- R5: When more than one enabled filter matches, the lowest-numbered filter wins, and its number is reported on `res_index`.
- R6: `res_fifo` reports the 5-bit FIFO select of the winning filter, with values 0 to 31 naming FIFOs 0 to 31.
- R7: A disabled filter never matches. When no filter matches, `res_accept`, `res_index` and `res_fifo` are all 0.
- R8: A control write to an enabled filter leaves its mask select and FIFO select unchanged. The enable bit itself always takes the written value, so a filter can be disabled and then reprogrammed.
- R9: The address map is as follows.
  - Addresses 0 to 31 hold the filter words and addresses 32 to 35 hold the masks.
  - Addresses 40 to 47 hold the control registers. Register 40+k holds filters 4k to 4k+3, with filter 4k+j in byte j.
  - Within each control byte, bit 7 is the enable, bits 6:5 are the mask select and bits 4:0 are the FIFO select.
  - For control writes, `cfg_be[j]` gates byte j.
- R10: After a synchronous reset, all filters are disabled, all words are 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte strobes for control register writes |
| id_valid | input | 1 | Identifier present this cycle |
| id_ext | input | 1 | Frame uses an extended identifier |
| id_sid | input | 11 | Standard identifier part |
| id_eid | input | 18 | Extended identifier part |
| res_valid | output | 1 | Result valid, one cycle after id_valid |
| res_accept | output | 1 | At least one enabled filter matched |
| res_index | output | 5 | Number of the winning filter |
| res_fifo | output | 5 | Destination FIFO of the winning filter |

## Verification
The bench sends random identifiers of two kinds. Some are built from a chosen filter with only the don't-care bits randomized. These near hits test the mask and type logic and often collide with other filters, which tests the priority rule. The rest are fully random identifiers, which mostly test the no-hit path. Directed cases cover the remaining rules:
- Two identical filters, which shows whether the lower one wins.
- Standard and extended frames against a type-checking mask.
- An extended-bit difference sent as a standard frame, where it must be ignored.
- Filter 31 routed to FIFO 31.
- Field writes to an enabled filter, which must leave its routing unchanged.
- Control writes with partial byte strobes.

// File: rtl/can_fb_pkg.sv
package can_fb_pkg;
  localparam int SID_W   = 11;
  localparam int EID_W   = 18;
  localparam int SID_LSB = 21;
  localparam int XID_BIT = 19;
  localparam int CB_EN   = 7;
  localparam int CB_MS   = 5;

  typedef struct packed {
    logic [SID_W-1:0] sid;
    logic             xid;
    logic [EID_W-1:0] eid;
  } id_word_t;

  function automatic id_word_t unpack_word(input logic [31:0] w);
    id_word_t r;
    r.sid = w[SID_LSB +: SID_W];
    r.xid = w[XID_BIT];
    r.eid = w[EID_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/can_fb_cfg.sv
module can_fb_cfg
  import can_fb_pkg::*;
#(
  parameter int NUM_FILT = 32,
  parameter int NUM_MASK = 4,
  parameter int NUM_FIFO = 32,
  parameter int ADDR_W   = 6,
  localparam int MS_W    = $clog2(NUM_MASK),
  localparam int FS_W    = $clog2(NUM_FIFO)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output id_word_t          filt_w [NUM_FILT],
  output id_word_t          mask_w [NUM_MASK],
  output logic              en     [NUM_FILT],
  output logic [MS_W-1:0]   msel   [NUM_FILT],
  output logic [FS_W-1:0]   fsel   [NUM_FILT]
);
  localparam int MASK_BASE = NUM_FILT;
  localparam int CTRL_BASE = NUM_FILT + 8;
  localparam int NUM_CREG  = NUM_FILT / 4;

  logic wr_filt, wr_mask, wr_ctrl;
  always_comb begin
    wr_filt = we && (int'(addr) < MASK_BASE);
    wr_mask = we && (int'(addr) >= MASK_BASE) && (int'(addr) < MASK_BASE + NUM_MASK);
    wr_ctrl = we && (int'(addr) >= CTRL_BASE) && (int'(addr) < CTRL_BASE + NUM_CREG);
  end

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
    localparam int CREG = f / 4;
    localparam int LANE = f % 4;
    logic hit_word, hit_ctrl;
    assign hit_word = wr_filt && (int'(addr) == f);
    assign hit_ctrl = wr_ctrl && (int'(addr) == CTRL_BASE + CREG) && be[LANE];

    always_ff @(posedge clk) begin
      if (rst) begin
        filt_w[f] <= '0;
        en[f]     <= 1'b0;
        msel[f]   <= '0;
        fsel[f]   <= '0;
      end else begin
        if (hit_word) filt_w[f] <= unpack_word(wdata);
        if (hit_ctrl) begin
          en[f] <= wdata[8*LANE + CB_EN];
          if (!en[f]) begin
            msel[f] <= wdata[8*LANE + CB_MS +: MS_W];
            fsel[f] <= wdata[8*LANE +: FS_W];
          end
        end
      end
    end

    // R8
    locked_fields_chk: assert property (@(posedge clk) disable iff (rst)
      (hit_ctrl && en[f]) |=> ($stable(msel[f]) && $stable(fsel[f])));
  end

  for (genvar m = 0; m < NUM_MASK; m++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) mask_w[m] <= '0;
      else if (wr_mask && (int'(addr) == MASK_BASE + m)) mask_w[m] <= unpack_word(wdata);
    end
  end
endmodule

// File: rtl/can_fb_match.sv
module can_fb_match
  import can_fb_pkg::*;
#(
  parameter int NUM_FILT = 32,
  parameter int NUM_MASK = 4,
  localparam int MS_W    = $clog2(NUM_MASK)
) (
  input  logic             ext,
  input  logic [SID_W-1:0] sid,
  input  logic [EID_W-1:0] eid,
  input  id_word_t         filt_w [NUM_FILT],
  input  id_word_t         mask_w [NUM_MASK],
  input  logic             en     [NUM_FILT],
  input  logic [MS_W-1:0]  msel   [NUM_FILT],
  output logic [NUM_FILT-1:0] hits
);
  for (genvar f = 0; f < NUM_FILT; f++) begin : g_cmp
    id_word_t m;
    logic sid_ok, eid_ok, typ_ok;
    always_comb begin
      m      = mask_w[msel[f]];
      sid_ok = ((sid ^ filt_w[f].sid) & m.sid) == '0;
      eid_ok = !ext || (((eid ^ filt_w[f].eid) & m.eid) == '0);
      typ_ok = !m.xid || (ext == filt_w[f].xid);
      hits[f] = en[f] && sid_ok && eid_ok && typ_ok;
    end
  end
endmodule

// File: rtl/can_fb_prio.sv
module can_fb_prio #(
  parameter int NUM = 32,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic [NUM-1:0]   req,
  output logic [NUM-1:0]   grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_filter_bank.sv
module can_filter_bank
  import can_fb_pkg::*;
#(
  parameter int NUM_FILT = 32,
  parameter int NUM_MASK = 4,
  parameter int NUM_FIFO = 32,
  parameter int ADDR_W   = 6,
  localparam int MS_W    = $clog2(NUM_MASK),
  localparam int FS_W    = $clog2(NUM_FIFO),
  localparam int IDX_W   = $clog2(NUM_FILT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [3:0]        cfg_be,
  input  logic              id_valid,
  input  logic              id_ext,
  input  logic [SID_W-1:0]  id_sid,
  input  logic [EID_W-1:0]  id_eid,
  output logic              res_valid,
  output logic              res_accept,
  output logic [IDX_W-1:0]  res_index,
  output logic [FS_W-1:0]   res_fifo
);
  id_word_t          filt_w [NUM_FILT];
  id_word_t          mask_w [NUM_MASK];
  logic              en     [NUM_FILT];
  logic [MS_W-1:0]   msel   [NUM_FILT];
  logic [FS_W-1:0]   fsel   [NUM_FILT];
  logic [NUM_FILT-1:0] hits, grant;
  logic [IDX_W-1:0]  win_idx;
  logic              win_any;

  can_fb_cfg #(.NUM_FILT(NUM_FILT), .NUM_MASK(NUM_MASK), .NUM_FIFO(NUM_FIFO),
               .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .be(cfg_be), .filt_w(filt_w), .mask_w(mask_w), .en(en), .msel(msel),
    .fsel(fsel));

  can_fb_match #(.NUM_FILT(NUM_FILT), .NUM_MASK(NUM_MASK)) u_match (
    .ext(id_ext), .sid(id_sid), .eid(id_eid), .filt_w(filt_w),
    .mask_w(mask_w), .en(en), .msel(msel), .hits(hits));

  can_fb_prio #(.NUM(NUM_FILT)) u_prio (
    .req(hits), .grant(grant), .idx(win_idx), .any(win_any));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_index  <= '0;
      res_fifo   <= '0;
    end else begin
      res_valid <= id_valid;
      if (id_valid) begin
        res_accept <= win_any;
        res_index  <= win_any ? win_idx : '0;
        res_fifo   <= win_any ? fsel[win_idx] : '0;
      end
    end
  end

  // R5: the grant is a single filter, one that hit, with no hit below it
  always_comb begin
    if (!rst) begin
      grant_onehot_chk: assert ($onehot0(grant));
      grant_in_hits_chk: assert ((grant & ~hits) == '0);
      grant_lowest_chk: assert (((grant - 1'b1) & hits) == '0 || grant == '0);
    end
  end

  // R1
  result_latency_chk: assert property (@(posedge clk) disable iff (rst)
    id_valid |=> res_valid);
  // R1
  result_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !id_valid |=> (!res_valid && $stable(res_accept) && $stable(res_fifo)));
  // R7
  empty_result_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_accept) |-> (res_index == '0 && res_fifo == '0));
endmodule

// File: tb/can_filter_bank_tb.sv
module can_filter_bank_tb;
  logic        clk = 0, rst = 1;
  logic        cfg_we = 0;
  logic [5:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [3:0]  cfg_be = 0;
  logic        id_valid = 0, id_ext = 0;
  logic [10:0] id_sid = 0;
  logic [17:0] id_eid = 0;
  logic        res_valid, res_accept;
  logic [4:0]  res_index, res_fifo;

  int errors = 0, checks = 0;
  logic [31:0] m_filt [32];
  logic [31:0] m_mask [4];
  logic        m_en   [32];
  logic [1:0]  m_ms   [32];
  logic [4:0]  m_fs   [32];

  always #2 clk = ~clk;

  can_filter_bank u_dut (.*);

  function automatic bit flt_match(int f, bit ext, logic [10:0] sid, logic [17:0] eid);
    logic [31:0] fw, mw;
    fw = m_filt[f];
    mw = m_mask[m_ms[f]];
    if (!m_en[f]) return 0;
    if (((sid ^ fw[31:21]) & mw[31:21]) != 0) return 0;
    if (ext && (((eid ^ fw[17:0]) & mw[17:0]) != 0)) return 0;
    if (mw[19] && (ext != fw[19])) return 0;
    return 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_we = 0;
    if (a < 32) m_filt[a] = d;
    else if (a < 36) m_mask[a-32] = d;
    else if (a >= 40 && a < 48) begin
      for (int j = 0; j < 4; j++) if (be[j]) begin
        int f = 4*(a-40) + j;
        if (!m_en[f]) begin m_ms[f] = d[8*j+5 +: 2]; m_fs[f] = d[8*j +: 5]; end
        m_en[f] = d[8*j+7];
      end
    end
  endtask

  task automatic lookup(string req, bit ext, logic [10:0] sid, logic [17:0] eid);
    int win = -1;
    for (int f = 31; f >= 0; f--) if (flt_match(f, ext, sid, eid)) win = f;
    @(negedge clk);
    id_valid = 1; id_ext = ext; id_sid = sid; id_eid = eid;
    @(negedge clk);
    id_valid = 0;
    check({req, " R1 valid"}, res_valid, 1);
    check({req, " R7 accept"}, res_accept, win >= 0);
    check({req, " R5 index"}, res_index, win >= 0 ? win : 0);
    check({req, " R6 fifo"}, res_fifo, win >= 0 ? m_fs[win] : 0);
    @(negedge clk);
    check({req, " R1 drop"}, res_valid, 0);
  endtask

  function automatic logic [31:0] mkw(logic [10:0] s, bit x, logic [17:0] e);
    return {s, 1'b0, x, 1'b0, e};
  endfunction

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    for (int i = 0; i < 32; i++) begin m_filt[i] = 0; m_en[i] = 0; m_ms[i] = 0; m_fs[i] = 0; end
    for (int i = 0; i < 4; i++) m_mask[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 valid", res_valid, 0);
    check("R10 accept", res_accept, 0);
    lookup("R10 all disabled", 0, 11'h0, 18'h0);

    // R2 full-compare mask 0 on filter 2, route to fifo 7
    wr(32, 32'hFFEB_FFFF, 4'hF);
    wr(2, mkw(11'h123, 1, 18'h2_5A5A), 4'hF);
    wr(40, 32'h0087_0000, 4'h4);
    lookup("R2 exact ext", 1, 11'h123, 18'h2_5A5A);
    lookup("R2 eid differs", 1, 11'h123, 18'h2_5A5B);
    lookup("R2 sid differs", 1, 11'h124, 18'h2_5A5A);
    // R3 type check on mask bit 19: standard frame rejected
    wr(32, 32'hFFE8_0000 | 32'h0008_0000, 4'hF);
    lookup("R3 type mismatch", 0, 11'h123, 18'h0);
    lookup("R3 type match", 1, 11'h123, 18'h3_FFFF);
    // type check off, standard frame, eid ignored
    wr(32, 32'hFFE0_0000, 4'hF);
    lookup("R2 std ignores eid", 0, 11'h123, 18'h1_1111);

    // R4 mask select 3 with loose mask on filter 9
    wr(35, 32'hF000_0000, 4'hF);
    wr(9, mkw(11'h500, 0, 18'h0), 4'hF);
    wr(42, 32'h0000_E300, 4'h2);
    lookup("R4 mask3 loose", 0, 11'h5AB, 18'h0);
    lookup("R4 mask3 reject", 0, 11'h6AB, 18'h0);

    // R5 lowest wins: filter 1 same as filter 2
    wr(1, mkw(11'h123, 1, 18'h2_5A5A), 4'hF);
    wr(40, 32'h0000_8300, 4'h2);
    lookup("R5 lower wins", 1, 11'h123, 18'h0);

    // R8 lock: change fifo of enabled filter 1 ignored
    wr(40, 32'h0000_9F00, 4'h2);
    lookup("R8 locked", 1, 11'h123, 18'h0);
    // R8 disable then reprogram
    wr(40, 32'h0000_1F00, 4'h2);
    lookup("R8 disabled", 1, 11'h123, 18'h0);
    wr(40, 32'h0000_9F00, 4'h2);
    lookup("R8 reprogrammed", 1, 11'h123, 18'h0);

    // R9 byte strobes / R6 boundary: filter 31 fifo 31 via lane 3 of reg 47
    wr(31, mkw(11'h7FF, 0, 18'h0), 4'hF);
    wr(33, 32'hFFE0_0000, 4'hF);
    wr(47, 32'hBFFF_FFFF, 4'h8);
    lookup("R9 lane3 R6 fifo31", 0, 11'h7FF, 18'h0);
    wr(47, 32'h0000_0000, 4'h7);
    lookup("R9 masked lanes", 0, 11'h7FF, 18'h0);

    // random
    for (int n = 0; n < 300; n++) begin
      int f;
      logic [31:0] mw, fw;
      bit ext;
      logic [10:0] s;
      logic [17:0] e;
      if (n % 40 == 0) begin
        for (int m = 0; m < 4; m++) wr(32 + m, $urandom() | ((m == 0) ? 32'hFFE0_0000 : 0), 4'hF);
        for (int k = 0; k < 8; k++) wr(40 + k, $urandom(), 4'(($urandom() % 15) + 1));
        for (int k = 0; k < 8; k++) wr($urandom() % 32, $urandom(), 4'hF);
      end
      f = $urandom() % 32;
      fw = m_filt[f]; mw = m_mask[m_ms[f]];
      if ($urandom() % 4 != 0) begin
        ext = mw[19] ? fw[19] : 1'($urandom());
        s = fw[31:21] ^ (11'($urandom()) & ~mw[31:21]);
        e = fw[17:0] ^ (18'($urandom()) & ~mw[17:0]);
      end else begin
        ext = 1'($urandom()); s = 11'($urandom()); e = 18'($urandom());
      end
      lookup("random R2 R3 R4 R5 R6 R7", ext, s, e);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule